// File: doc/BRIEF.md
# Soft-Decision Threshold Sensing Sequencer

This block runs one soft-decision read of a two-bit-per-cell flash cell. Software first fills a small table with reference codes in ascending order. It then pulses `start`. The sequencer applies the references to the cell comparator one at a time. Each reference is held for a programmable number of clock cycles. The sequence stops at the first reference at which the comparator reports that the cell conducts. The table may hold an evenly spaced ladder, or levels packed tightly around the three hard-decision boundaries (a hard reference flanked by two borders, so nine or fifteen levels in total). Either way, the sequencer returns a compact range index and the number of steps it spent.

Range index k means the cell threshold lies above reference k-1 and at or below reference k. Index 0 means the threshold is at or below the first reference. An index equal to the level count means the cell never conducted, so the threshold is above the last reference. Read latency is the number of steps multiplied by the step length. A non-uniform list therefore gives useful soft information from far fewer steps than a fine uniform ladder.

Top module: `soft_sense_seq`

## Requirements
- R1: After reset, `busy`, `done`, `range_idx`, `steps_taken` and `vref` are all zero.
- R2: During step k (counted from 0), `vref` equals table entry k for the whole step, and k only ever increases by one. While idle, `vref` is 0.
- R3: The cell conducts in a step when `cell_on` is high in the last cycle of that step. The read ends at the first such step k and reports `range_idx` = k.
- R4: If the cell has not conducted after the last level, `range_idx` equals the effective level count N (meaning above the highest reference).
- R5: `steps_taken` equals `range_idx`+1 when the cell conducted, and N otherwise.
- R6: A step lasts L = `cfg_step_cyc` cycles, with 0 taken as 1. `done` is high in the cycle that begins `steps_taken`*L clock edges after the edge that accepts `start`.
- R7: `done` is high for exactly one cycle, and `busy` falls at the same edge. The results hold until the next accepted start.
- R8: Table writes and `start` pulses that occur while `busy` is high are ignored. They do not change the current read or any later read.
- R9: The effective level count N is `cfg_levels`, clamped to the range 1..MAX_LVL. A value of 0 gives one level; a value above the table depth gives the table depth.
- R10: `cfg_levels` and `cfg_step_cyc` are sampled only at the accepting edge. Changing them during a read has no effect on that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the reference table |
| cfg_addr | input | IDX_W | Table entry to write |
| cfg_ref | input | REF_W | Reference code to write |
| cfg_levels | input | LVL_W | Number of levels to apply in a read |
| cfg_step_cyc | input | CNT_W | Clock cycles per sensing step |
| start | input | 1 | Begin a read when idle |
| cell_on | input | 1 | Comparator result: the cell conducts at `vref` |
| busy | output | 1 | Read in progress |
| done | output | 1 | One-cycle completion pulse |
| vref | output | REF_W | Reference code currently applied |
| range_idx | output | LVL_W | Quantized threshold interval |
| steps_taken | output | LVL_W | Number of levels applied |

## Verification
The situation hardest to reach from the ports is a read that is disturbed while it runs. In the middle of a long read, the bench issues in one cycle a table write that would move the result, a second `start`, and new level and step-length settings. It then checks that the result, the latency and the applied reference sequence all match an undisturbed read, and it repeats the read to show the table entry kept its old value. The never-conducting case at full table depth is reached by filling all entries and asking for more levels than exist. This confirms both the clamp and the top index.

// File: rtl/ss_pkg.sv
package ss_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SENSE = 1'b1
    } seq_state_e;

    // Clamp a requested level count into 1..max_lvl.
    function automatic int unsigned clamp_levels(int unsigned req, int unsigned max_lvl);
        if (req == 0)       return 1;
        if (req > max_lvl)  return max_lvl;
        return req;
    endfunction

    // A zero step length is taken as one cycle.
    function automatic int unsigned eff_step_len(int unsigned req);
        return (req == 0) ? 1 : req;
    endfunction

endpackage

// File: rtl/ss_ref_table.sv
module ss_ref_table #(
    parameter int REF_W = 8,
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [REF_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [REF_W-1:0] rd_data
);

    logic [REF_W-1:0] ent_q [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                ent_q[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                ent_q[i] <= wr_data;
            end
        end
    end

    assign rd_data = ent_q[rd_idx];

endmodule

// File: rtl/ss_step_timer.sv
module ss_step_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    input  logic             run,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len - 1'b1;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = run && (cnt_q == '0);

endmodule

// File: rtl/ss_seq_ctrl.sv
module ss_seq_ctrl
    import ss_pkg::*;
#(
    parameter int LVL_W = 6,
    parameter int IDX_W = 5,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cell_on,
    input  logic             expire,
    input  logic [IDX_W-1:0] cfg_last,
    input  logic [CNT_W-1:0] cfg_len,
    output logic             tim_load,
    output logic [CNT_W-1:0] tim_len,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] step_idx,
    output logic [LVL_W-1:0] range_idx,
    output logic [LVL_W-1:0] steps_taken
);

    typedef struct packed {
        logic [LVL_W-1:0] idx;
        logic [LVL_W-1:0] cnt;
    } result_t;

    seq_state_e       state_q;
    logic [IDX_W-1:0] step_q;
    logic [IDX_W-1:0] last_q;
    logic [CNT_W-1:0] len_q;
    result_t          res_q;
    result_t          res_d;
    logic             done_q;

    logic accept, at_last, advance, finish;

    always_comb begin
        accept  = (state_q == ST_IDLE) && start;
        at_last = (step_q == last_q);
        advance = (state_q == ST_SENSE) && expire && !cell_on && !at_last;
        finish  = (state_q == ST_SENSE) && expire && (cell_on || at_last);
        res_d.cnt = LVL_W'(step_q) + 1'b1;
        res_d.idx = cell_on ? LVL_W'(step_q) : (LVL_W'(last_q) + 1'b1);
    end

    assign tim_load = accept || advance;
    assign tim_len  = accept ? cfg_len : len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            last_q  <= '0;
            len_q   <= '0;
            res_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                state_q <= ST_SENSE;
                step_q  <= '0;
                last_q  <= cfg_last;
                len_q   <= cfg_len;
            end else if (advance) begin
                step_q <= step_q + 1'b1;
            end else if (finish) begin
                state_q <= ST_IDLE;
                res_q   <= res_d;
                done_q  <= 1'b1;
            end
        end
    end

    assign busy        = (state_q == ST_SENSE);
    assign done        = done_q;
    assign step_idx    = step_q;
    assign range_idx   = res_q.idx;
    assign steps_taken = res_q.cnt;

endmodule

// File: rtl/soft_sense_seq.sv
module soft_sense_seq
    import ss_pkg::*;
#(
    parameter int REF_W   = 8,
    parameter int MAX_LVL = 32,
    parameter int CNT_W   = 16,
    localparam int IDX_W  = $clog2(MAX_LVL),
    localparam int LVL_W  = $clog2(MAX_LVL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_addr,
    input  logic [REF_W-1:0] cfg_ref,
    input  logic [LVL_W-1:0] cfg_levels,
    input  logic [CNT_W-1:0] cfg_step_cyc,
    input  logic             start,
    input  logic             cell_on,
    output logic             busy,
    output logic             done,
    output logic [REF_W-1:0] vref,
    output logic [LVL_W-1:0] range_idx,
    output logic [LVL_W-1:0] steps_taken
);

    logic [LVL_W-1:0] eff_levels;
    logic [IDX_W-1:0] eff_last;
    logic [CNT_W-1:0] eff_len;
    logic             tim_load;
    logic [CNT_W-1:0] tim_len;
    logic             expire;
    logic [IDX_W-1:0] step_q;
    logic [REF_W-1:0] tbl_rd;
    logic             busy_w;

    always_comb begin
        eff_levels = LVL_W'(clamp_levels(32'(cfg_levels), MAX_LVL));
        eff_last   = IDX_W'(eff_levels - 1'b1);
        eff_len    = CNT_W'(eff_step_len(32'(cfg_step_cyc)));
    end

    ss_ref_table #(
        .REF_W (REF_W),
        .DEPTH (MAX_LVL)
    ) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we && !busy_w),
        .wr_idx  (cfg_addr),
        .wr_data (cfg_ref),
        .rd_idx  (step_q),
        .rd_data (tbl_rd)
    );

    ss_step_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (tim_load),
        .len    (tim_len),
        .run    (busy_w),
        .expire (expire)
    );

    ss_seq_ctrl #(
        .LVL_W (LVL_W),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .cell_on     (cell_on),
        .expire      (expire),
        .cfg_last    (eff_last),
        .cfg_len     (eff_len),
        .tim_load    (tim_load),
        .tim_len     (tim_len),
        .busy        (busy_w),
        .done        (done),
        .step_idx    (step_q),
        .range_idx   (range_idx),
        .steps_taken (steps_taken)
    );

    assign busy = busy_w;
    assign vref = busy_w ? tbl_rd : '0;

endmodule

// File: rtl/ss_seq_chk.sv
module ss_seq_chk #(
    parameter int REF_W = 8,
    parameter int LVL_W = 6,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             cell_on,
    input logic [REF_W-1:0] vref,
    input logic [LVL_W-1:0] range_idx,
    input logic [LVL_W-1:0] steps_taken,
    input logic [IDX_W-1:0] step_idx
);

    // R7
    done_with_fall_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    steps_rel_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ((steps_taken == range_idx + 1'b1) || (steps_taken == range_idx)));

    // R3
    hit_seen_chk: assert property (@(posedge clk) disable iff (rst)
        (done && (steps_taken == range_idx + 1'b1)) |-> $past(cell_on));

    // R3
    no_skip_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && (step_idx != $past(step_idx))) |-> !$past(cell_on));

    // R2
    step_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && (step_idx != $past(step_idx))) |-> (step_idx == $past(step_idx) + 1'b1));

    // R2
    vref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && (step_idx == $past(step_idx))) |-> $stable(vref));

    // R2
    vref_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (vref == '0));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> ($stable(range_idx) && $stable(steps_taken)));

endmodule

bind soft_sense_seq ss_seq_chk #(
    .REF_W (REF_W),
    .LVL_W (LVL_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .done        (done),
    .cell_on     (cell_on),
    .vref        (vref),
    .range_idx   (range_idx),
    .steps_taken (steps_taken),
    .step_idx    (step_q)
);

// File: tb/soft_sense_seq_tb.sv
`timescale 1ns/1ps
module soft_sense_seq_tb;

    localparam int REF_W   = 8;
    localparam int MAX_LVL = 32;
    localparam int CNT_W   = 16;
    localparam int IDX_W   = $clog2(MAX_LVL);
    localparam int LVL_W   = $clog2(MAX_LVL + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic [IDX_W-1:0] cfg_addr = '0;
    logic [REF_W-1:0] cfg_ref = '0;
    logic [LVL_W-1:0] cfg_levels = '0;
    logic [CNT_W-1:0] cfg_step_cyc = '0;
    logic             start = 1'b0;
    logic             cell_on;
    logic             busy, done;
    logic [REF_W-1:0] vref;
    logic [LVL_W-1:0] range_idx, steps_taken;

    int vth_r = 0;
    int tb_tbl [MAX_LVL];
    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    // cell model: conducts once the applied reference reaches its threshold
    assign cell_on = (32'(vref) >= vth_r);

    soft_sense_seq #(
        .REF_W   (REF_W),
        .MAX_LVL (MAX_LVL),
        .CNT_W   (CNT_W)
    ) u_dut (
        .clk          (clk),
        .rst          (rst),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_ref      (cfg_ref),
        .cfg_levels   (cfg_levels),
        .cfg_step_cyc (cfg_step_cyc),
        .start        (start),
        .cell_on      (cell_on),
        .busy         (busy),
        .done         (done),
        .vref         (vref),
        .range_idx    (range_idx),
        .steps_taken  (steps_taken)
    );

    // mode: 0 uniform 6, 1 clustered 9, 2 clustered 15, 3 uniform 15, 4 uniform 31, 5 uniform 32
    typedef struct packed {
        logic [2:0] mode;
        logic [7:0] vth;
        logic [3:0] sc;
        logic [5:0] eidx;
        logic [5:0] esteps;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{3'd0, 8'd130, 4'd2, 6'd5,  6'd6},
        '{3'd0, 8'd0,   4'd3, 6'd0,  6'd1},
        '{3'd0, 8'd151, 4'd1, 6'd6,  6'd6},
        '{3'd1, 8'd61,  4'd2, 6'd2,  6'd3},
        '{3'd1, 8'd60,  4'd1, 6'd1,  6'd2},
        '{3'd1, 8'd100, 4'd3, 6'd3,  6'd4},
        '{3'd1, 8'd189, 4'd2, 6'd9,  6'd9},
        '{3'd2, 8'd121, 4'd1, 6'd8,  6'd9},
        '{3'd2, 8'd188, 4'd2, 6'd14, 6'd15},
        '{3'd3, 8'd17,  4'd3, 6'd2,  6'd3},
        '{3'd4, 8'd241, 4'd1, 6'd31, 6'd31},
        '{3'd4, 8'd100, 4'd2, 6'd13, 6'd14}
    };

    function automatic int mode_len(int m);
        case (m)
            0: return 6;
            1: return 9;
            2: return 15;
            3: return 15;
            4: return 31;
            default: return 32;
        endcase
    endfunction

    function automatic int ref_val(int m, int k);
        case (m)
            0: return k * 30;
            1: return 60 * (k / 3 + 1) + ((k % 3) - 1) * 8;
            2: return 60 * (k / 5 + 1) + ((k % 5) - 2) * 4;
            3: return k * 16;
            default: return k * 8;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_mode(input int m);
        for (int k = 0; k < mode_len(m); k++) begin
            @(negedge clk);
            cfg_we   = 1'b1;
            cfg_addr = IDX_W'(k);
            cfg_ref  = REF_W'(ref_val(m, k));
            tb_tbl[k] = ref_val(m, k);
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_read(input int vth, input int nl, input int sc, input bit disturb,
                            output int idx, output int st, output int cyc, output bit vok);
        int len;
        len = (sc == 0) ? 1 : sc;
        vth_r = vth;
        @(negedge clk);
        cfg_levels   = LVL_W'(nl);
        cfg_step_cyc = CNT_W'(sc);
        start        = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        vok = 1'b1;
        while (!done && cyc < 5000) begin
            if (!busy || (32'(vref) != tb_tbl[(cyc / len) % MAX_LVL])) vok = 1'b0;
            if (disturb && cyc == 1) begin
                cfg_we = 1'b1; cfg_addr = IDX_W'(4); cfg_ref = 8'd200;
                start = 1'b1; cfg_levels = LVL_W'(1); cfg_step_cyc = CNT_W'(7);
            end else if (disturb && cyc == 2) begin
                cfg_we = 1'b0; start = 1'b0;
                cfg_levels = LVL_W'(nl); cfg_step_cyc = CNT_W'(sc);
            end
            @(negedge clk);
            cyc++;
        end
        idx = int'(range_idx);
        st  = int'(steps_taken);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int idx, st, cyc, len, cur;
        bit vok;
        for (int i = 0; i < MAX_LVL; i++) tb_tbl[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(range_idx == '0 && steps_taken == '0, "R1 results", int'(range_idx) + int'(steps_taken), 0);
        chk(vref == '0, "R1 vref", int'(vref), 0);

        cur = -1;
        for (int i = 0; i < 12; i++) begin
            if (int'(VECS[i].mode) != cur) begin
                cur = int'(VECS[i].mode);
                load_mode(cur);
            end
            len = (VECS[i].sc == 0) ? 1 : int'(VECS[i].sc);
            run_read(int'(VECS[i].vth), mode_len(cur), int'(VECS[i].sc), 1'b0, idx, st, cyc, vok);
            if (int'(VECS[i].eidx) == mode_len(cur))
                chk(idx == int'(VECS[i].eidx), "R4 top index", idx, int'(VECS[i].eidx));
            else
                chk(idx == int'(VECS[i].eidx), "R3 first conducting index", idx, int'(VECS[i].eidx));
            chk(st == int'(VECS[i].esteps), "R5 steps", st, int'(VECS[i].esteps));
            chk(cyc == int'(VECS[i].esteps) * len, "R6 latency", cyc, int'(VECS[i].esteps) * len);
            chk(vok, "R2 reference order", int'(vok), 1);
        end

        // R7: done lasts one cycle, results hold
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R7 done pulse", int'(done), 0);
        chk(int'(range_idx) == 13, "R7 result held", int'(range_idx), 13);

        // R8 / R10: disturbance mid-read
        load_mode(0);
        run_read(130, 6, 2, 1'b1, idx, st, cyc, vok);
        chk(idx == 5, "R8 write during read ignored", idx, 5);
        chk(cyc == 12, "R10 config latched latency", cyc, 12);
        chk(st == 6, "R10 level count latched", st, 6);
        chk(vok, "R8 restart ignored", int'(vok), 1);
        run_read(130, 6, 1, 1'b0, idx, st, cyc, vok);
        chk(idx == 5, "R8 table entry unchanged", idx, 5);

        // R9: zero level count becomes one
        run_read(130, 0, 2, 1'b0, idx, st, cyc, vok);
        chk(idx == 1 && st == 1, "R9 zero levels", idx * 100 + st, 101);
        chk(cyc == 2, "R9 zero levels latency", cyc, 2);

        // R6: zero step length becomes one cycle
        run_read(61, 6, 0, 1'b0, idx, st, cyc, vok);
        chk(idx == 3, "R6 zero step index", idx, 3);
        chk(cyc == 4, "R6 zero step latency", cyc, 4);

        // R9 / R4: over-range level count on full table, never conducts
        load_mode(5);
        run_read(250, 40, 1, 1'b0, idx, st, cyc, vok);
        chk(idx == 32, "R9 clamp top index", idx, 32);
        chk(st == 32 && cyc == 32, "R9 clamp steps", st, 32);
        chk(vok, "R2 full table order", int'(vok), 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule